// File: doc/BRIEF.md
# Wakeup Filter Configuration Register Bank

This block is the software-facing configuration store for the power-management wakeup logic of an Ethernet MAC. It sits on a simple 32-bit memory-mapped slave bus with an address, a write strobe, a read strobe, write data and read data. Two offsets are decoded. The filter window offset gives access to eight 32-bit filter registers that have no addresses of their own. The power-management offset holds control bits and wakeup status flags.

A 3-bit hidden pointer selects the filter register. Each read or write at the filter window uses the register under the pointer and then moves the pointer on by one. Software therefore loads or dumps the whole filter set with eight back-to-back accesses. A self-clearing bit in the power-management register sends the pointer back to zero. The stored filter words are split into per-filter fields: byte masks, commands, offsets and CRC-16 values. These fields drive the frame-matching logic, which lives outside this block.

The frame matcher and the magic-packet detector raise single-cycle event pulses. A pulse is recorded only while the block is powered down and the matching detection is enabled. A recorded pulse ends power-down. The recorded flags clear when software reads the register.

Top module: `wkf_regs`

## Requirements
- R1: After reset, every filter register, every control bit and every status flag is zero, and the pointer is 0.
- R2: Reads and writes at offset 0x28 share one pointer. The pointer selects filter register 0..7, advances by one after each access and wraps from 7 to 0. Eight consecutive writes load registers 0..7, and eight consecutive reads return them in that order.
- R3: Filter registers 0..3 drive the byte mask of filters 0..3. Byte n of register 5 is the offset of filter n. Register 6 holds the CRC-16 of filter 0 in bits 15:0 and of filter 1 in bits 31:16. Register 7 does the same for filters 2 and 3.
- R4: In filter register 4, bits [8n+3:8n] are the command of filter n. Bits [8n+7:8n+4] read as zero and ignore writes.
- R5: Writing 1 to bit 31 at offset 0x2C sets the pointer to 0, so the next filter access uses register 0. A read of 0x2C in the cycle straight after that write shows bit 31 as 1. Later reads show it as 0.
- R6: Offset 0x2C layout: bit 0 power-down, bit 1 magic-packet enable, bit 2 wakeup-frame enable, bit 5 magic-packet received, bit 6 wakeup-frame received, bit 9 global unicast. The two enables and global unicast are read/write. All other bits read as zero.
- R7: Software can only set power-down. Writing 0 to bit 0 leaves it unchanged.
- R8: A wakeup-frame or magic-packet event pulse sets its received flag and clears power-down. This happens only if the matching enable and power-down are both 1. Otherwise the pulse has no effect.
- R9: A read of 0x2C returns the flags and then clears them. If an event that counts arrives in the same cycle as that read, the flag is set afterwards.
- R10: Writes to bits 5 and 6 of 0x2C have no effect on the flags.
- R11: With the read strobe low, or at any other offset, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | AW | Byte offset of the access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational in the read cycle |
| evWake | input | 1 | Wakeup-frame match pulse |
| evMagic | input | 1 | Magic-packet match pulse |
| filtByteMask | output | NFILT*32 | Byte masks, filter 0 lowest |
| filtCmd | output | NFILT*4 | Commands, filter 0 lowest |
| filtOffset | output | NFILT*8 | Offsets, filter 0 lowest |
| filtCrc | output | NFILT*16 | CRC-16 values, filter 0 lowest |
| pwrDown | output | 1 | Power-down state |
| magicEn | output | 1 | Magic-packet detection enable |
| wakeEn | output | 1 | Wakeup-frame detection enable |
| globUcast | output | 1 | Global unicast enable |

## Verification
Directed sequences run the pointer through a full eight-write load and an eight-read dump. They then break a sequence with a pointer reset in the middle, which shows whether the reset lands on the next access or is late by one. Event pulses are applied with power-down off, with the enable off, and with both on, so that correct gating can be told apart from flags that are always set. An event placed on the same cycle as a clearing read checks which of the two takes priority. A long run with a fixed seed then mixes writes, reads, stray offsets and events, and compares every read word and every field output against a bench model.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  localparam int DW    = 32;
  localparam int NREG  = 8;
  localparam int PW    = $clog2(NREG);
  localparam int NFILT = 4;
  localparam int CMDW  = 4;
  localparam int OFSW  = 8;
  localparam int CRCW  = 16;

  localparam int CMD_REG  = 4;
  localparam int OFS_REG  = 5;
  localparam int CRC_REG0 = 6;

  localparam int PD_B   = 0;
  localparam int MPE_B  = 1;
  localparam int WFE_B  = 2;
  localparam int MPR_B  = 5;
  localparam int WFR_B  = 6;
  localparam int GU_B   = 9;
  localparam int PRST_B = 31;

  localparam logic [DW-1:0] CMD_KEEP = 32'h0F0F_0F0F;

  typedef struct packed {
    logic          filtWr;
    logic          filtRd;
    logic [PW-1:0] ptr;
    logic          csrWr;
    logic          csrRd;
    logic          ptrRstPend;
  } wkf_strb_t;
endpackage

// File: rtl/wkf_ctrl.sv
module wkf_ctrl
  import wkf_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] FILT_OFS = 8'h28,
  parameter logic [AW-1:0] CSR_OFS  = 8'h2C
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          busRe,
  input  logic          ptrRstReq,
  output wkf_strb_t     strb
);
  logic          hitFilt;
  logic          hitCsr;
  logic          filtAcc;
  logic          ptrRstNow;
  logic [PW-1:0] ptr;
  logic          rstPend;

  assign hitFilt   = (busAddr == FILT_OFS);
  assign hitCsr    = (busAddr == CSR_OFS);
  assign filtAcc   = hitFilt && (busWe || busRe);
  assign ptrRstNow = hitCsr && busWe && ptrRstReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      rstPend <= 1'b0;
    end else begin
      rstPend <= ptrRstNow;
      if (ptrRstNow) begin
        ptr <= '0;
      end else if (filtAcc) begin
        ptr <= (ptr == PW'(NREG - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_comb begin
    strb.filtWr     = hitFilt && busWe;
    strb.filtRd     = hitFilt && busRe;
    strb.ptr        = ptr;
    strb.csrWr      = hitCsr && busWe;
    strb.csrRd      = hitCsr && busRe;
    strb.ptrRstPend = rstPend;
  end
endmodule

// File: rtl/wkf_data.sv
module wkf_data
  import wkf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  wkf_strb_t             strb,
  input  logic [DW-1:0]         busWdata,
  input  logic                  evWake,
  input  logic                  evMagic,
  output logic [DW-1:0]         rdFilt,
  output logic [DW-1:0]         rdCsr,
  output logic [NFILT*DW-1:0]   filtByteMask,
  output logic [NFILT*CMDW-1:0] filtCmd,
  output logic [NFILT*OFSW-1:0] filtOffset,
  output logic [NFILT*CRCW-1:0] filtCrc,
  output logic                  pwrDown,
  output logic                  magicEn,
  output logic                  wakeEn,
  output logic                  globUcast,
  output logic                  wakeRcvd,
  output logic                  magicRcvd
);
  logic [DW-1:0] filtReg [NREG];
  logic          wakeHit;
  logic          magicHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) filtReg[i] <= '0;
    end else if (strb.filtWr) begin
      for (int i = 0; i < NREG; i++) begin
        if (strb.ptr == PW'(i)) begin
          filtReg[i] <= (i == CMD_REG) ? (busWdata & CMD_KEEP) : busWdata;
        end
      end
    end
  end

  assign rdFilt = filtReg[strb.ptr];

  assign wakeHit  = evWake && wakeEn && pwrDown;
  assign magicHit = evMagic && magicEn && pwrDown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrDown   <= 1'b0;
      magicEn   <= 1'b0;
      wakeEn    <= 1'b0;
      globUcast <= 1'b0;
      wakeRcvd  <= 1'b0;
      magicRcvd <= 1'b0;
    end else begin
      if (wakeHit || magicHit) begin
        pwrDown <= 1'b0;
      end else if (strb.csrWr && busWdata[PD_B]) begin
        pwrDown <= 1'b1;
      end
      if (strb.csrWr) begin
        magicEn   <= busWdata[MPE_B];
        wakeEn    <= busWdata[WFE_B];
        globUcast <= busWdata[GU_B];
      end
      if (wakeHit) wakeRcvd <= 1'b1;
      else if (strb.csrRd) wakeRcvd <= 1'b0;
      if (magicHit) magicRcvd <= 1'b1;
      else if (strb.csrRd) magicRcvd <= 1'b0;
    end
  end

  always_comb begin
    rdCsr         = '0;
    rdCsr[PD_B]   = pwrDown;
    rdCsr[MPE_B]  = magicEn;
    rdCsr[WFE_B]  = wakeEn;
    rdCsr[MPR_B]  = magicRcvd;
    rdCsr[WFR_B]  = wakeRcvd;
    rdCsr[GU_B]   = globUcast;
    rdCsr[PRST_B] = strb.ptrRstPend;
  end

  for (genvar f = 0; f < NFILT; f++) begin : g_fld
    assign filtByteMask[f*DW +: DW]   = filtReg[f];
    assign filtCmd[f*CMDW +: CMDW]    = filtReg[CMD_REG][f*8 +: CMDW];
    assign filtOffset[f*OFSW +: OFSW] = filtReg[OFS_REG][f*OFSW +: OFSW];
    assign filtCrc[f*CRCW +: CRCW]    = filtReg[CRC_REG0 + f/2][(f%2)*CRCW +: CRCW];
  end
endmodule

// File: rtl/wkf_regs.sv
module wkf_regs
  import wkf_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] FILT_OFS = 8'h28,
  parameter logic [AW-1:0] CSR_OFS  = 8'h2C
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [AW-1:0]         busAddr,
  input  logic                  busWe,
  input  logic                  busRe,
  input  logic [DW-1:0]         busWdata,
  output logic [DW-1:0]         busRdata,
  input  logic                  evWake,
  input  logic                  evMagic,
  output logic [NFILT*DW-1:0]   filtByteMask,
  output logic [NFILT*CMDW-1:0] filtCmd,
  output logic [NFILT*OFSW-1:0] filtOffset,
  output logic [NFILT*CRCW-1:0] filtCrc,
  output logic                  pwrDown,
  output logic                  magicEn,
  output logic                  wakeEn,
  output logic                  globUcast
);
  wkf_strb_t     strb;
  logic [DW-1:0] rdFilt;
  logic [DW-1:0] rdCsr;
  logic          wakeRcvd;
  logic          magicRcvd;

  wkf_ctrl #(.AW(AW), .FILT_OFS(FILT_OFS), .CSR_OFS(CSR_OFS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busRe     (busRe),
    .ptrRstReq (busWdata[PRST_B]),
    .strb      (strb)
  );

  wkf_data u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWdata     (busWdata),
    .evWake       (evWake),
    .evMagic      (evMagic),
    .rdFilt       (rdFilt),
    .rdCsr        (rdCsr),
    .filtByteMask (filtByteMask),
    .filtCmd      (filtCmd),
    .filtOffset   (filtOffset),
    .filtCrc      (filtCrc),
    .pwrDown      (pwrDown),
    .magicEn      (magicEn),
    .wakeEn       (wakeEn),
    .globUcast    (globUcast),
    .wakeRcvd     (wakeRcvd),
    .magicRcvd    (magicRcvd)
  );

  always_comb begin
    if (strb.filtRd)     busRdata = rdFilt;
    else if (strb.csrRd) busRdata = rdCsr;
    else                 busRdata = '0;
  end
endmodule

// File: rtl/wkf_regs_chk.sv
module wkf_regs_chk
  import wkf_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input wkf_strb_t     strb,
  input logic [DW-1:0] busWdata,
  input logic [DW-1:0] busRdata,
  input logic          evWake,
  input logic          evMagic,
  input logic          pwrDown,
  input logic          wakeEn,
  input logic          magicEn,
  input logic          wakeRcvd
);
  logic acc;
  logic prstWr;
  assign acc    = strb.filtWr || strb.filtRd;
  assign prstWr = strb.csrWr && busWdata[PRST_B];

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc && (strb.ptr == PW'(NREG - 1)) |=> strb.ptr == '0);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc && (strb.ptr != PW'(NREG - 1)) |=> strb.ptr == $past(strb.ptr) + 1'b1);

  // R2
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acc && !prstWr |=> $stable(strb.ptr));

  // R5
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    prstWr |=> (strb.ptr == '0) && strb.ptrRstPend);

  // R5
  prst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !prstWr |=> !strb.ptrRstPend);

  // R6
  csr_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.csrRd |-> (busRdata[30:10] == '0) && (busRdata[8:7] == '0) && (busRdata[4:3] == '0));

  // R7
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown && !(evWake && wakeEn) && !(evMagic && magicEn) |=> pwrDown);

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wakeRcvd && !(evWake && wakeEn && pwrDown) |=> !wakeRcvd);

  // R9
  wake_win_chk: assert property (@(posedge clk) disable iff (!rstN)
    evWake && wakeEn && pwrDown |=> wakeRcvd && !pwrDown);
endmodule

bind wkf_regs wkf_regs_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strb     (strb),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .evWake   (evWake),
  .evMagic  (evMagic),
  .pwrDown  (pwrDown),
  .wakeEn   (wakeEn),
  .magicEn  (magicEn),
  .wakeRcvd (wakeRcvd)
);

// File: tb/wkf_regs_bench.sv
`timescale 1ns/1ps
module wkf_regs_bench;
  localparam logic [7:0] FA = 8'h28;
  localparam logic [7:0] CA = 8'h2C;
  localparam logic [7:0] XA = 8'h30;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWe = 1'b0;
  logic          busRe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          evWake = 1'b0;
  logic          evMagic = 1'b0;
  logic [127:0]  filtByteMask;
  logic [15:0]   filtCmd;
  logic [31:0]   filtOffset;
  logic [63:0]   filtCrc;
  logic          pwrDown, magicEn, wakeEn, globUcast;

  always #10 clk = ~clk;

  wkf_regs u_wkf_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .evWake(evWake), .evMagic(evMagic),
    .filtByteMask(filtByteMask), .filtCmd(filtCmd), .filtOffset(filtOffset),
    .filtCrc(filtCrc), .pwrDown(pwrDown), .magicEn(magicEn), .wakeEn(wakeEn),
    .globUcast(globUcast)
  );

  int nChk = 0;
  int nFail = 0;
  logic done = 1'b0;

  logic [31:0] mFilt [8];
  logic [2:0]  mPtr;
  logic        mPd, mMpe, mWfe, mGu, mMpr, mWfr, mPrst;

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mFilt[i] = '0;
    mPtr = '0; mPd = 0; mMpe = 0; mWfe = 0; mGu = 0; mMpr = 0; mWfr = 0; mPrst = 0;
  endtask

  function automatic logic [31:0] expCsr();
    logic [31:0] v = '0;
    v[0] = mPd; v[1] = mMpe; v[2] = mWfe; v[5] = mMpr; v[6] = mWfr; v[9] = mGu; v[31] = mPrst;
    return v;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a, input logic re);
    if (!re) return '0;
    if (a == FA) return mFilt[mPtr];
    if (a == CA) return expCsr();
    return '0;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs();
    logic [127:0] m;
    logic [15:0]  c;
    logic [31:0]  o;
    logic [63:0]  r;
    for (int f = 0; f < 4; f++) begin
      m[f*32 +: 32] = mFilt[f];
      c[f*4 +: 4]   = mFilt[4][f*8 +: 4];
      o[f*8 +: 8]   = mFilt[5][f*8 +: 8];
    end
    r = {mFilt[7], mFilt[6]};
    check("R3 byte masks", filtByteMask, m);
    check("R4 commands", 128'(filtCmd), 128'(c));
    check("R3 offsets", 128'(filtOffset), 128'(o));
    check("R3 crc values", 128'(filtCrc), 128'(r));
    check("R6 control outputs", 128'({pwrDown, magicEn, wakeEn, globUcast}),
          128'({mPd, mMpe, mWfe, mGu}));
  endtask

  task automatic doCycle(input logic [7:0] a, input logic we, input logic re,
                         input logic [31:0] wd, input logic ew, input logic em,
                         input string tag);
    logic wh, mh;
    @(negedge clk);
    busAddr = a; busWe = we; busRe = re; busWdata = wd; evWake = ew; evMagic = em;
    #2;
    if (re) check(tag, 128'(busRdata), 128'(expRead(a, re)));
    else    check("R11 idle read", 128'(busRdata), 128'(0));
    checkOutputs();
    // next state from the requirements
    wh = ew && mWfe && mPd;
    mh = em && mMpe && mPd;
    mPrst = 1'b0;
    if (a == FA && (we || re)) begin
      if (we) mFilt[mPtr] = (mPtr == 3'd4) ? (wd & 32'h0F0F_0F0F) : wd;
      mPtr = mPtr + 1'b1;
    end
    if (a == CA && we) begin
      if (wd[31]) begin mPtr = '0; mPrst = 1'b1; end
      mMpe = wd[1]; mWfe = wd[2]; mGu = wd[9];
    end
    if (wh || mh) mPd = 1'b0;
    else if (a == CA && we && wd[0]) mPd = 1'b1;
    if (wh) mWfr = 1'b1; else if (a == CA && re) mWfr = 1'b0;
    if (mh) mMpr = 1'b1; else if (a == CA && re) mMpr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    doCycle(CA, 0, 1, 0, 0, 0, "R1 csr after reset");
    doCycle(FA, 0, 1, 0, 0, 0, "R1 filter 0 after reset");
    doCycle(CA, 1, 0, 32'h8000_0000, 0, 0, "R5 pointer reset");
    // R2 full load then dump
    for (int i = 0; i < 8; i++)
      doCycle(FA, 1, 0, (i == 4) ? 32'hFFFF_FFFF : (32'h1357_0000 + 32'(i * 32'h0101)), 0, 0, "R2 load");
    for (int i = 0; i < 8; i++)
      doCycle(FA, 0, 1, 0, 0, 0, (i == 4) ? "R4 reserved command bits" : "R2 ordered dump");
    doCycle(FA, 0, 1, 0, 0, 0, "R2 wrap to register 0");
    // R5 pointer reset mid-sequence
    doCycle(FA, 1, 0, 32'hCAFE_0001, 0, 0, "R2 partial load");
    doCycle(FA, 1, 0, 32'hCAFE_0002, 0, 0, "R2 partial load");
    doCycle(CA, 1, 0, 32'h8000_0000, 0, 0, "R5 pointer reset");
    doCycle(CA, 0, 1, 0, 0, 0, "R5 bit reads one right after");
    doCycle(CA, 0, 1, 0, 0, 0, "R5 bit reads zero later");
    doCycle(FA, 0, 1, 0, 0, 0, "R5 access lands on register 0");
    // R6 and R7
    doCycle(CA, 1, 0, 32'h0000_0207, 0, 0, "R6 set controls");
    doCycle(CA, 0, 1, 0, 0, 0, "R6 control readback");
    doCycle(CA, 1, 0, 32'h7FFF_FC00, 0, 0, "R7 write zero to power-down");
    doCycle(CA, 0, 1, 0, 0, 0, "R7 power-down kept");
    // R8 gating: power-down on, enable off
    doCycle(CA, 0, 0, 0, 1, 1, "R8 event with enables off");
    doCycle(CA, 0, 1, 0, 0, 0, "R8 no flag without enable");
    doCycle(CA, 1, 0, 32'h0000_0007, 0, 0, "R8 enable both");
    doCycle(CA, 0, 0, 0, 1, 0, "R8 wake event");
    doCycle(CA, 0, 1, 0, 0, 0, "R8 wake flag set and power-down cleared");
    doCycle(CA, 0, 1, 0, 0, 0, "R9 flag cleared by read");
    doCycle(CA, 0, 0, 0, 1, 1, "R8 event while awake");
    doCycle(CA, 0, 1, 0, 0, 0, "R8 no flag while awake");
    // R9 collision
    doCycle(CA, 1, 0, 32'h0000_0007, 0, 0, "R9 arm");
    doCycle(CA, 0, 1, 0, 0, 1, "R9 read coincides with event");
    doCycle(CA, 0, 1, 0, 0, 0, "R9 event wins over clear");
    // R10 flags not writable
    doCycle(CA, 1, 0, 32'h0000_0060, 0, 0, "R10 write flag bits");
    doCycle(CA, 0, 1, 0, 0, 0, "R10 flags stay clear");
    // R11 stray offset
    doCycle(XA, 1, 1, 32'hFFFF_FFFF, 0, 0, "R11 unmapped offset");
    doCycle(FA, 0, 0, 0, 0, 0, "R11 idle");
    // random mix, fixed seed
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] a = (k < 5) ? FA : (k < 9) ? CA : XA;
      logic we = $urandom_range(0, 1) == 1;
      logic re = !we || ($urandom_range(0, 3) == 0 && a != FA);
      logic [31:0] wd = $urandom();
      if (a == CA && $urandom_range(0, 3) != 0) wd[31] = 1'b0;
      doCycle(a, we, re, wd, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
              (a == FA) ? "R2 random" : (a == CA) ? "R6 random" : "R11 random");
    end
    doCycle(XA, 0, 0, 0, 0, 0, "R11 idle end");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule